// File: doc/BRIEF.md
# Multi-mode barrel shifter

A purely combinational shifter that moves a W-bit word (default 8) by any amount from 0 to W-1 positions in one pass. Three mode inputs select the operation: a direction input picks left or right, an arithmetic input picks sign fill for right shifts and overflow reporting for left shifts, and a rotate input wraps the bits that leave one end back in at the other. The rotate input takes precedence over the arithmetic input.

The datapath is a chain of log2(W) stages. Stage k looks only at bit k of the amount and either passes its word through or moves it by 2^k places. A separate detector watches the original word and raises an overflow flag when an arithmetic left shift cannot keep the value's sign. The block sits between a register file and a result bus, and it adds no state or latency.

Top module: `bshift_top`

## Requirements
- R1: With an amount of 0, `res` equals `din` and `ovf` is 0 in every mode.
- R2: Logical right shift (`to_left`=0, `arith`=0, `rot`=0) gives `din >> amt`, and the vacated high bits are 0.
- R3: Arithmetic right shift (`to_left`=0, `arith`=1, `rot`=0) fills the vacated high bits with `din[W-1]`. For example, 0xFA by 1 gives 0xFD.
- R4: Left shift without rotate gives `din << amt` in both the logical and the arithmetic mode. The vacated low bits are 0 and the bits pushed past the top are lost.
- R5: Rotate left (`to_left`=1, `rot`=1) moves the bits leaving the top back into the low end, so bit i of `res` is `din[(i-amt) mod W]`.
- R6: Rotate right (`to_left`=0, `rot`=1) moves the bits leaving the bottom back into the high end, so bit i of `res` is `din[(i+amt) mod W]`.
- R7: With `rot`=1 the result does not depend on `arith`.
- R8: In arithmetic left shift, `ovf` is 1 exactly when the top amt+1 bits of `din` are not all equal, that is, when a lost bit or the new sign bit differs from the old sign bit. For example, 0x80 by 1 flags and 0xF0 by 3 does not.
- R9: `ovf` is 0 for every right shift, for logical left shifts and for rotates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| din | input | W | Word to be shifted |
| amt | input | log2(W) | Shift distance |
| to_left | input | 1 | 1 = left, 0 = right |
| arith | input | 1 | 1 = arithmetic mode, 0 = logical mode |
| rot | input | 1 | 1 = rotate; overrides `arith` |
| res | output | W | Shifted word |
| ovf | output | 1 | Arithmetic left overflow |

## Verification
The shifted result and the overflow flag are produced in the same cycle by separate logic, and the cases where both matter are arithmetic left shifts that push a sign change out of the word. The bench drives these with values such as 0x40 and 0x0F, whose shifted word looks valid but has lost its sign, and with 0xF0 by 3, which shifts far but keeps its sign. Each case is judged on `res` and `ovf` together. A second shared case is rotate with `arith` held high: the result must equal the plain rotate, and the flag must stay low.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_SIGN = 2'd1,
    FILL_WRAP = 2'd2
  } fill_kind_e;

  // Decode the fill policy used by every stage.
  function automatic fill_kind_e pick_fill(input logic to_left, input logic arith,
                                           input logic rot);
    if (rot) return FILL_WRAP;
    if (arith && !to_left) return FILL_SIGN;
    return FILL_ZERO;
  endfunction

endpackage

// File: rtl/bshift_stage.sv
module bshift_stage
  import bshift_pkg::*;
#(
  parameter int W    = 8,
  parameter int DIST = 1
) (
  input  logic [W-1:0] d_in,
  input  logic         en,
  input  logic         to_left,
  input  fill_kind_e   kind,
  input  logic         sign,
  output logic [W-1:0] d_out
);
  logic [DIST-1:0] fill_r, fill_l;
  logic [W-1:0]    moved;

  always_comb begin
    case (kind)
      FILL_WRAP: begin
        fill_r = d_in[DIST-1:0];
        fill_l = d_in[W-1 -: DIST];
      end
      FILL_SIGN: begin
        fill_r = {DIST{sign}};
        fill_l = '0;
      end
      default: begin
        fill_r = '0;
        fill_l = '0;
      end
    endcase
    if (to_left) moved = {d_in[W-1-DIST:0], fill_l};
    else         moved = {fill_r, d_in[W-1:DIST]};
    d_out = en ? moved : d_in;
  end
endmodule

// File: rtl/bshift_ovf.sv
module bshift_ovf #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic          active,
  output logic          ovf
);
  // Mask of the top n+1 bits: the lost bits plus the new sign position.
  function automatic logic [W-1:0] top_mask(input logic [AW-1:0] n);
    logic [W-1:0] m;
    m = '1;
    m = m << (W - 1 - int'(n));
    return m;
  endfunction

  logic [W-1:0] mask, window;

  always_comb begin
    mask   = top_mask(amt);
    window = din & mask;
    ovf    = active && (window != '0) && (window != mask);
  end
endmodule

// File: rtl/bshift_top.sv
module bshift_top
  import bshift_pkg::*;
#(
  parameter int W  = 8,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic          to_left,
  input  logic          arith,
  input  logic          rot,
  output logic [W-1:0]  res,
  output logic          ovf
);
  fill_kind_e   kind;
  logic [W-1:0] stage_bus [AW+1];
  logic         ovf_active;

  assign kind         = pick_fill(to_left, arith, rot);
  assign stage_bus[0] = din;
  assign ovf_active   = to_left && arith && !rot;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    bshift_stage #(.W(W), .DIST(1 << k)) u_stage (
      .d_in    (stage_bus[k]),
      .en      (amt[k]),
      .to_left (to_left),
      .kind    (kind),
      .sign    (din[W-1]),
      .d_out   (stage_bus[k+1])
    );
  end

  bshift_ovf #(.W(W), .AW(AW)) u_ovf (
    .din    (din),
    .amt    (amt),
    .active (ovf_active),
    .ovf    (ovf)
  );

  assign res = stage_bus[AW];
endmodule

// File: rtl/bshift_chk.sv
module bshift_chk #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input logic [W-1:0]  din,
  input logic [AW-1:0] amt,
  input logic          to_left,
  input logic          arith,
  input logic          rot,
  input logic [W-1:0]  res,
  input logic          ovf
);
  always_comb begin
    // R1
    p_zero_pass_r1: assert (amt != '0 || (res == din && !ovf))
      else $error("zero amount changed data");
    // R9
    p_no_overflow_r9: assert ((to_left && arith && !rot) || !ovf)
      else $error("overflow outside arithmetic left");
    // R5 / R6: a rotate keeps every bit
    p_rot_keep_r5: assert (!rot || $countones(res) == $countones(din))
      else $error("rotate lost bits");
    // R4
    p_left_fill_r4: assert (!(to_left && !rot && amt != '0) || !res[0])
      else $error("left shift low bit not zero");
    // R2
    p_lsr_top_r2: assert (!(!to_left && !arith && !rot && amt != '0) || !res[W-1])
      else $error("logical right top bit not zero");
    // R3
    p_asr_sign_r3: assert (!(!to_left && arith && !rot) || res[W-1] == din[W-1])
      else $error("arithmetic right lost sign");
  end
endmodule

bind bshift_top bshift_chk #(.W(W), .AW(AW)) u_chk (
  .din(din), .amt(amt), .to_left(to_left), .arith(arith), .rot(rot),
  .res(res), .ovf(ovf)
);

// File: tb/sim_bshift_top.sv
`timescale 1ns/1ps
module sim_bshift_top;
  localparam int W  = 8;
  localparam int AW = 3;
  localparam int NV = 14;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0]  din = '0;
  logic [AW-1:0] amt = '0;
  logic to_left = 1'b0, arith = 1'b0, rot = 1'b0;
  logic [W-1:0]  res;
  logic          ovf;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  bshift_top #(.W(W)) u0 (
    .din(din), .amt(amt), .to_left(to_left), .arith(arith), .rot(rot),
    .res(res), .ovf(ovf)
  );

  // {din, amt, to_left, arith, rot, exp_res, exp_ovf}
  localparam logic [22:0] VEC [NV] = '{
    {8'hFA, 3'd1, 1'b0, 1'b1, 1'b0, 8'hFD, 1'b0}, // R3
    {8'hFA, 3'd1, 1'b0, 1'b0, 1'b0, 8'h7D, 1'b0}, // R2
    {8'h80, 3'd1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1}, // R8
    {8'h80, 3'd1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0}, // R9
    {8'h07, 3'd1, 1'b1, 1'b1, 1'b0, 8'h0E, 1'b0}, // R4
    {8'hAB, 3'd1, 1'b1, 1'b0, 1'b1, 8'h57, 1'b0}, // R5
    {8'hAB, 3'd1, 1'b0, 1'b0, 1'b1, 8'hD5, 1'b0}, // R6
    {8'hAB, 3'd3, 1'b0, 1'b1, 1'b1, 8'h75, 1'b0}, // R7
    {8'h96, 3'd0, 1'b1, 1'b1, 1'b0, 8'h96, 1'b0}, // R1
    {8'h40, 3'd1, 1'b1, 1'b1, 1'b0, 8'h80, 1'b1}, // R8
    {8'hF0, 3'd3, 1'b1, 1'b1, 1'b0, 8'h80, 1'b0}, // R8
    {8'h81, 3'd7, 1'b0, 1'b1, 1'b0, 8'hFF, 1'b0}, // R3
    {8'h81, 3'd7, 1'b0, 1'b0, 1'b0, 8'h01, 1'b0}, // R2
    {8'h0F, 3'd4, 1'b1, 1'b1, 1'b0, 8'hF0, 1'b1}  // R8
  };

  // Bench model: bit-by-bit source selection.
  function automatic logic [W:0] model(input logic [W-1:0] d, input int n,
                                       input logic l, input logic a, input logic r);
    logic [W-1:0] o;
    logic         f;
    for (int i = 0; i < W; i++) begin
      int src;
      src = l ? i - n : i + n;
      if (src >= 0 && src < W) o[i] = d[src];
      else if (r)              o[i] = d[(src + W) % W];
      else if (!l && a)        o[i] = d[W-1];
      else                     o[i] = 1'b0;
    end
    f = 1'b0;
    if (l && a && !r)
      for (int j = W - 1 - n; j < W; j++) if (d[j] != d[W-1]) f = 1'b1;
    return {o, f};
  endfunction

  task automatic check(input string req, input logic [W-1:0] er, input logic eo);
    n_checks++;
    if (res !== er || ovf !== eo) begin
      n_fail++;
      $display("FAIL %s din=%h amt=%0d l=%b a=%b r=%b: res=%h ovf=%b expected res=%h ovf=%b",
               req, din, amt, to_left, arith, rot, res, ovf, er, eo);
    end
  endtask

  task automatic apply(input logic [W-1:0] d, input logic [AW-1:0] n,
                       input logic l, input logic a, input logic r);
    @(negedge clk);
    din = d; amt = n; to_left = l; arith = a; rot = r;
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: res=%h expected completion", res);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [W:0] e;
    logic [W:0] e0;
    // Initial state: all-zero inputs give all-zero outputs (R1)
    @(posedge clk); #1;
    check("R1", '0, 1'b0);

    for (int v = 0; v < NV; v++) begin
      logic [22:0] t;
      t = VEC[v];
      apply(t[22:15], t[14:12], t[11], t[10], t[9]);
      check("R1-R9 table", t[8:1], t[0]);
    end

    // Directed: zero amount in every mode (R1)
    for (int m = 0; m < 8; m++) begin
      apply(8'hC3, '0, m[2], m[1], m[0]);
      check("R1", 8'hC3, 1'b0);
    end

    // Directed: rotate ignores arith (R7), compared at the ports
    for (int n = 0; n < W; n++) begin
      apply(8'h6D, n[AW-1:0], 1'b1, 1'b0, 1'b1);
      e0 = {res, ovf};
      apply(8'h6D, n[AW-1:0], 1'b1, 1'b1, 1'b1);
      check("R7", e0[W:1], e0[0]);
    end

    // Sweep against the bench model (R2-R6, R8, R9)
    for (int d = 0; d < 256; d++)
      for (int n = 0; n < W; n++)
        for (int m = 0; m < 8; m++) begin
          e = model(d[W-1:0], n, m[2], m[1], m[0]);
          apply(d[W-1:0], n[AW-1:0], m[2], m[1], m[0]);
          if (m[0])       check(m[2] ? "R5" : "R6", e[W:1], e[0]);
          else if (m[2])  check(m[1] ? "R8" : "R4", e[W:1], e[0]);
          else            check(m[1] ? "R3" : "R2", e[W:1], e[0]);
        end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule